// File: doc/BRIEF.md
# Converter Result Status and Interrupt Unit

This unit sits between a simple register bus and a multi-channel analog-to-digital converter. It holds the control bits that switch the converter on and start or stop conversion, and it captures each finished conversion result in a result register. It also tracks whether the converter is busy and which channel it is sampling. Software drives it through two bus addresses: one control/status word and one result word.

Each conversion-done pulse loads the result and raises a completion flag. Reading the result word clears that flag as a side effect. If a new result arrives while the flag is still set, the old result is replaced and an overwrite flag is raised, so the loss is reported rather than hidden. The overwrite flag is cleared by writing a one to its bit. A single level interrupt output combines both flags with their enable bits.

Top module: `adc_status_regs`

## Requirements
- R1: After reset the control/status word reads 0x0000, the result word reads 0x0000, `irq` is 0, and `conv_en` and `conv_run` are 0.
- R2: Control/status word (address 0) layout: bit 0 enable, bit 1 run, bit 4 completion interrupt enable, bit 5 overwrite interrupt enable, bit 8 completion flag, bit 9 overwrite flag, bit 10 busy, bits 14:12 channel. Bits 15, 11, 7:6 and 3:2 always read 0, whatever was written to them. Addresses other than 0 and 1 read 0.
- R3: A write to address 0 loads bits 0, 1, 4 and 5. The run bit is stored only if the enable bit in the same write is 1, otherwise it becomes 0. The `conv_en` and `conv_run` outputs follow the stored enable and run bits.
- R4: A trigger pulse while enable and run are both 1 sets busy. Busy returns to 0 one cycle after the run bit becomes 0.
- R5: A trigger pulse while enable and run are 1 latches `cnv_chan` (0 to 5) into bits 14:12.
- R6: A done pulse while enabled loads `cnv_data` into the result word (address 1) and sets the completion flag.
- R7: A read of address 1 clears the completion flag when no done pulse is accepted in the same cycle.
- R8: A done pulse accepted while the completion flag is 1 and no result read happens in that cycle replaces the result, sets the overwrite flag and leaves the completion flag at 1.
- R9: Writing 1 to bit 9 clears the overwrite flag, and writing 0 there leaves it unchanged. An overwrite event in the same cycle as a clearing write leaves the flag at 1.
- R10: `irq` is 1 exactly while (completion flag and bit 4) or (overwrite flag and bit 5) holds.
- R11: A done pulse in the same cycle as a result read leaves the completion flag at 1 and raises no overwrite.
- R12: While enable is 0, done and trigger pulses change neither the result, the flags, busy nor the channel. Writing enable 0 clears run at once and clears busy one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Register address: 0 control/status, 1 result |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle. Read data is valid in the same cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed word |
| cnv_trig | input | 1 | Start-of-sampling pulse from the converter |
| cnv_done | input | 1 | Conversion-done pulse |
| cnv_data | input | DATA_W | Result that goes with the done pulse |
| cnv_chan | input | CHAN_W | Channel being sampled |
| conv_en | output | 1 | Stored enable bit, to the converter |
| conv_run | output | 1 | Stored run bit, to the converter |
| irq | output | 1 | Level interrupt request |

## Verification
The checker watches every cycle for the flag rules. It checks that an accepted done sets the completion flag, that a lone result read clears it, and that an overwrite is raised only when no read comes in the same cycle. It also checks that the overwrite flag survives writes that do not clear it, that busy drops after run goes low, that results stay frozen while disabled, and that reserved bits read zero. Only the bench scenarios show the full set of same-cycle combinations of pending flag, read and done. The same holds for the exact values of the stored channel and result, the enable-gated run bit, and the interrupt level under each enable setting.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int unsigned CSR_W     = 16;
  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_RUN     = 1;
  localparam int unsigned B_CIE     = 4;
  localparam int unsigned B_OIE     = 5;
  localparam int unsigned B_CF      = 8;
  localparam int unsigned B_OW      = 9;
  localparam int unsigned B_BUSY    = 10;
  localparam int unsigned B_CHAN_LO = 12;

  typedef struct packed {
    logic en;
    logic run;
    logic cie;
    logic oie;
  } ctl_t;

  typedef struct packed {
    logic busy;
    logic cf;
    logic ow;
  } flg_t;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
  import adc_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] wdata,
  output ctl_t             ctl
);
  ctl_t ctl_q;
  ctl_t ctl_n;
  logic ctl_ld;

  assign ctl_ld = csr_wr;

  always_comb begin
    ctl_n     = ctl_q;
    ctl_n.en  = wdata[B_EN];
    ctl_n.run = wdata[B_RUN] & wdata[B_EN];
    ctl_n.cie = wdata[B_CIE];
    ctl_n.oie = wdata[B_OIE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_ld) begin
      ctl_q <= ctl_n;
    end
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/adc_flag_unit.sv
module adc_flag_unit
  import adc_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic              trig,
  input  logic              done,
  input  logic [DATA_W-1:0] res_in,
  input  logic [CHAN_W-1:0] chan_in,
  input  logic              res_rd,
  input  logic              ow_clr,
  output flg_t              flg,
  output logic [CHAN_W-1:0] chan,
  output logic [DATA_W-1:0] result
);
  flg_t              flg_q, flg_n;
  logic [CHAN_W-1:0] chan_q;
  logic [DATA_W-1:0] res_q;
  logic              evt_done;
  logic              evt_trig;
  logic              res_ld;
  logic              chan_ld;

  assign evt_done = done & ctl.en;
  assign evt_trig = trig & ctl.en & ctl.run;
  assign res_ld   = evt_done;
  assign chan_ld  = evt_trig;

  always_comb begin
    flg_n      = flg_q;
    flg_n.busy = ctl.en & ctl.run & (flg_q.busy | evt_trig);
    if (evt_done) begin
      flg_n.cf = 1'b1;
    end else if (res_rd) begin
      flg_n.cf = 1'b0;
    end
    if (evt_done && flg_q.cf && !res_rd) begin
      flg_n.ow = 1'b1;
    end else if (ow_clr) begin
      flg_n.ow = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      flg_q <= flg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_ld) begin
      res_q <= res_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (chan_ld) begin
      chan_q <= chan_in;
    end
  end

  assign flg    = flg_q;
  assign chan   = chan_q;
  assign result = res_q;
endmodule

// File: rtl/adc_irq_gen.sv
module adc_irq_gen
  import adc_stat_pkg::*;
(
  input  ctl_t ctl,
  input  flg_t flg,
  output logic irq
);
  logic cmp_req;
  logic ovr_req;

  assign cmp_req = flg.cf & ctl.cie;
  assign ovr_req = flg.ow & ctl.oie;
  assign irq     = cmp_req | ovr_req;
endmodule

// File: rtl/adc_status_regs.sv
module adc_status_regs
  import adc_stat_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CHAN_W   = 3,
  parameter int unsigned CSR_ADDR = 0,
  parameter int unsigned RES_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CSR_W-1:0]  bus_wdata,
  output logic [CSR_W-1:0]  bus_rdata,
  input  logic              cnv_trig,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data,
  input  logic [CHAN_W-1:0] cnv_chan,
  output logic              conv_en,
  output logic              conv_run,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CSR_ADDR);
  localparam logic [ADDR_W-1:0] A_RES = ADDR_W'(RES_ADDR);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              csr_sel;
  logic              res_sel;
  logic              csr_wr;
  logic              res_rd;
  logic              ow_clr;
  ctl_t              ctl;
  flg_t              flg;
  logic [CHAN_W-1:0] chan;
  logic [DATA_W-1:0] result;
  logic [CSR_W-1:0]  csr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  assign csr_sel = (bus_addr == A_CSR);
  assign res_sel = (bus_addr == A_RES);
  assign csr_wr  = bus_wr & csr_sel;
  assign res_rd  = bus_rd & res_sel;
  assign ow_clr  = csr_wr & bus_wdata[B_OW];

  adc_ctrl_reg i_ctrl (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .csr_wr (csr_wr),
    .wdata  (bus_wdata),
    .ctl    (ctl)
  );

  adc_flag_unit #(
    .DATA_W (DATA_W),
    .CHAN_W (CHAN_W)
  ) i_flags (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctl     (ctl),
    .trig    (cnv_trig),
    .done    (cnv_done),
    .res_in  (cnv_data),
    .chan_in (cnv_chan),
    .res_rd  (res_rd),
    .ow_clr  (ow_clr),
    .flg     (flg),
    .chan    (chan),
    .result  (result)
  );

  adc_irq_gen i_irq (
    .ctl (ctl),
    .flg (flg),
    .irq (irq)
  );

  always_comb begin
    csr_val                      = '0;
    csr_val[B_EN]                = ctl.en;
    csr_val[B_RUN]               = ctl.run;
    csr_val[B_CIE]               = ctl.cie;
    csr_val[B_OIE]               = ctl.oie;
    csr_val[B_CF]                = flg.cf;
    csr_val[B_OW]                = flg.ow;
    csr_val[B_BUSY]              = flg.busy;
    csr_val[B_CHAN_LO +: CHAN_W] = chan;
  end

  always_comb begin
    if (csr_sel) begin
      bus_rdata = csr_val;
    end else if (res_sel) begin
      bus_rdata = CSR_W'(result);
    end else begin
      bus_rdata = '0;
    end
  end

  assign conv_en  = ctl.en;
  assign conv_run = ctl.run;
endmodule

// File: rtl/adc_status_regs_chk.sv
module adc_status_regs_chk #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CSR_ADDR = 0,
  parameter int unsigned RES_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [15:0]       bus_wdata,
  input logic [15:0]       bus_rdata,
  input logic              cnv_done,
  input logic              en,
  input logic              run,
  input logic              cie,
  input logic              oie,
  input logic              busy,
  input logic              cf,
  input logic              ow,
  input logic [DATA_W-1:0] result,
  input logic              irq
);
  logic rd_res;
  logic ow_wr;
  logic acc;

  assign rd_res = bus_rd && (bus_addr == ADDR_W'(RES_ADDR));
  assign ow_wr  = bus_wr && (bus_addr == ADDR_W'(CSR_ADDR)) && bus_wdata[9];
  assign acc    = en && cnv_done;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CSR_ADDR)) |-> ((bus_rdata & 16'h88CC) == 16'h0000)); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !busy); // R4
  AST_CF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> cf); // R6
  AST_CF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !acc) |=> !cf); // R7
  AST_OW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cf && !rd_res) |=> (ow && cf)); // R8
  AST_OW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ow && !ow_wr) |=> ow); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cie && !oie) |-> !irq); // R10
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rd_res && !ow) |=> !ow); // R11
  AST_DIS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && cnv_done) |=> $stable(result)); // R12
endmodule

bind adc_status_regs adc_status_regs_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CSR_ADDR (CSR_ADDR),
  .RES_ADDR (RES_ADDR)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .cnv_done  (cnv_done),
  .en        (ctl.en),
  .run       (ctl.run),
  .cie       (ctl.cie),
  .oie       (ctl.oie),
  .busy      (flg.busy),
  .cf        (flg.cf),
  .ow        (flg.ow),
  .result    (result),
  .irq       (irq)
);

// File: tb/test_adc_status_regs.sv
`timescale 1ns/1ps
module test_adc_status_regs;
  logic        clk;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        cnv_trig;
  logic        cnv_done;
  logic [15:0] cnv_data;
  logic [2:0]  cnv_chan;
  logic        conv_en;
  logic        conv_run;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] exp_res;
  logic [15:0] rv;

  localparam logic [15:0] RUN = 16'h0033;
  localparam logic [15:0] OWC = 16'h0200;

  adc_status_regs i_adc_status_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnv_trig  (cnv_trig),
    .cnv_done  (cnv_done),
    .cnv_data  (cnv_data),
    .cnv_chan  (cnv_chan),
    .conv_en   (conv_en),
    .conv_run  (conv_run),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic done_pulse(input logic [15:0] d);
    cnv_data = d; cnv_done = 1'b1;
    @(negedge clk);
    cnv_done = 1'b0;
  endtask

  task automatic trig_pulse(input logic [2:0] c);
    cnv_chan = c; cnv_trig = 1'b1;
    @(negedge clk);
    cnv_trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    cnv_trig = 0; cnv_done = 0; cnv_data = '0; cnv_chan = '0;
    exp_res = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(2'd0, rv); chk("R1 csr", rv, 16'h0000);
    rd(2'd1, rv); chk("R1 result", rv, 16'h0000);
    chk("R1 irq/en/run", {13'd0, irq, conv_en, conv_run}, 16'h0000);

    // R2 R3 control field sweep with reserved bits written as ones
    for (int v = 0; v < 16; v++) begin
      logic [15:0] w, e;
      w = 16'h88CC | {10'd0, v[3], v[2], 2'b00, v[1], v[0]};
      e = {10'd0, v[3], v[2], 2'b00, v[1] & v[0], v[0]};
      wr(w);
      rd(2'd0, rv); chk("R3 R2 control readback", rv, e);
      chk("R3 conv_en/conv_run", {14'd0, conv_en, conv_run}, {14'd0, e[0], e[1]});
      chk("R10 irq idle", {15'd0, irq}, 16'h0000);
    end
    rd(2'd2, rv); chk("R2 unmapped addr 2", rv, 16'h0000);
    rd(2'd3, rv); chk("R2 unmapped addr 3", rv, 16'h0000);

    // R4 R5 channel sweep
    wr(RUN);
    for (int c = 0; c < 6; c++) begin
      trig_pulse(3'(c));
      rd(2'd0, rv); chk("R5 R4 channel and busy", rv, RUN | 16'h0400 | (16'(c) << 12));
    end
    wr(16'h0031);
    rd(2'd0, rv); chk("R4 busy one cycle after run drop", rv, 16'h5431);
    rd(2'd0, rv); chk("R4 busy cleared", rv, 16'h5031);

    // R6 R7 R8 R11 sweep: pending flag x read x done
    wr(RUN);
    for (int k = 0; k < 8; k++) begin
      logic cfp, rdv, dn, e_cf, e_ow;
      logic [15:0] b;
      cfp = k[2]; rdv = k[1]; dn = k[0];
      rd(2'd1, rv);
      wr(RUN | OWC);
      if (cfp) begin
        done_pulse(16'hA000 + 16'(k));
        exp_res = 16'hA000 + 16'(k);
      end
      b = 16'hB000 + 16'(k);
      bus_addr = 2'd1; bus_rd = rdv; cnv_done = dn; cnv_data = b;
      @(negedge clk);
      bus_rd = 1'b0; cnv_done = 1'b0;
      if (dn) exp_res = b;
      e_cf = dn | (cfp & ~rdv);
      e_ow = dn & cfp & ~rdv;
      chk("R10 irq level", {15'd0, irq}, {15'd0, e_cf | e_ow});
      rd(2'd0, rv);
      chk("R6 R7 R8 R11 flags", rv, 16'h5033 | {6'd0, e_ow, e_cf, 8'd0});
      rd(2'd1, rv); chk("R6 R8 result", rv, exp_res);
    end

    // R10 interrupt gating
    rd(2'd1, rv);
    wr(RUN | OWC);
    wr(16'h0003);
    done_pulse(16'h0001); exp_res = 16'h0001;
    chk("R10 cf without enable", {15'd0, irq}, 16'h0000);
    wr(16'h0013);
    chk("R10 cf with enable", {15'd0, irq}, 16'h0001);
    done_pulse(16'h0002); exp_res = 16'h0002;
    wr(16'h0023);
    chk("R10 ow with enable", {15'd0, irq}, 16'h0001);
    rd(2'd1, rv);
    chk("R10 ow holds irq after cf clear", {15'd0, irq}, 16'h0001);
    wr(16'h0003);
    chk("R10 ow without enable", {15'd0, irq}, 16'h0000);
    wr(16'h0023 | OWC);
    chk("R10 ow cleared", {15'd0, irq}, 16'h0000);

    // R9 write-one-to-clear
    done_pulse(16'h0003);
    done_pulse(16'h0004); exp_res = 16'h0004;
    wr(16'h0033);
    rd(2'd0, rv); chk("R9 write zero keeps ow", rv, 16'h5333);
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = 16'h0233;
    cnv_done = 1'b1; cnv_data = 16'h0005;
    @(negedge clk);
    bus_wr = 1'b0; cnv_done = 1'b0; exp_res = 16'h0005;
    rd(2'd0, rv); chk("R9 overwrite beats clear", rv, 16'h5333);
    wr(16'h0233);
    rd(2'd0, rv); chk("R9 write one clears ow", rv, 16'h5133);

    // R12 disabled inputs ignored
    rd(2'd1, rv); chk("R6 result before disable", rv, exp_res);
    wr(RUN);
    trig_pulse(3'd2);
    wr(16'h0000);
    @(negedge clk);
    rd(2'd0, rv); chk("R12 disable clears run and busy", rv, 16'h2000);
    done_pulse(16'hDEAD);
    trig_pulse(3'd4);
    rd(2'd0, rv); chk("R12 trig/done ignored csr", rv, 16'h2000);
    rd(2'd1, rv); chk("R12 result kept", rv, exp_res);
    chk("R12 conv_en low", {14'd0, conv_en, conv_run}, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule